// File: doc/BRIEF.md
# Indexed Register Bank Port

This block holds a small bank of 8-bit control registers behind a pair of neighbouring I/O addresses. The lower address holds an 8-bit pointer, and the upper address reaches the register that the pointer selects. The bank serves a display sequencer, a graphics controller or a CRT controller. Only the register count and the addresses differ between them, and all are set by parameters. The bank reports no meaning for any field. It exposes the register contents as one flat vector for the logic that uses them.

The bank accepts byte accesses at both addresses. A 16-bit write to the pointer address is a shortcut: it loads the pointer from the low byte and writes the high byte into the newly selected register. The pointer itself is never range-checked. Only data accesses are checked: an out-of-range data write is dropped, and an out-of-range data read returns zero. Every accepted data write produces a one-cycle update strobe carrying the pointer and the byte. Any other access width is refused with an error pulse.

An instance can also answer at a second address pair, chosen by a live select input. A CRT controller uses this to sit at either its monochrome or its colour location.

Top module: `ixreg_bank`

## Requirements
- R1: Synchronous active-high reset clears the pointer and every register to 0x00 and holds `io_rvalid`, `upd_stb` and `acc_err` low; a pointer read right after reset returns 0x00.
- R2: A byte write (`io_size`=0) to the pointer address stores all 8 bits of `io_wdata[7:0]` with no range check. A byte read of the pointer address returns the stored value on `io_rdata`, with `io_rvalid` high, one cycle after the request.
- R3: A byte write to the data address with pointer p < NREG stores `io_wdata[7:0]` into register p. The byte appears at `regs_o[8p+7:8p]` one cycle after the request.
- R4: A byte write to the data address with pointer p >= NREG leaves every register unchanged.
- R5: A byte read of the data address returns register p when p < NREG, and 0x00 when p >= NREG, one cycle after the request.
- R6: A 16-bit write (`io_size`=1) to the pointer address loads the pointer from `io_wdata[7:0]`. It then writes `io_wdata[15:8]` to the register that the new pointer selects, under the same range rule as R3 and R4.
- R7: Every accepted data write raises `upd_stb` for exactly one cycle, one cycle after the request, with `upd_idx` set to the target pointer and `upd_data` set to the byte. This holds for out-of-range writes and for the data half of a 16-bit write. No other access raises it.
- R8: Width code 0 is 8 bits, 1 is 16 bits, 2 is 32 bits and 3 is reserved. A decoded access with any width other than a byte, except a 16-bit write to the pointer address, raises `acc_err` one cycle later. It changes no state and gives no `io_rvalid`.
- R9: The pair responds at BASE_ADDR/BASE_ADDR+1, or at ALT_ADDR/ALT_ADDR+1 when ALT_EN is set and `alt_sel` is high. Accesses to any other address produce no response, no error and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alt_sel | input | 1 | Selects the alternate address pair (when ALT_EN) |
| io_wr | input | 1 | Write request, one cycle |
| io_rd | input | 1 | Read request, one cycle |
| io_addr | input | 16 | I/O address |
| io_size | input | 2 | Access width code: 0=8, 1=16, 2=32, 3=reserved |
| io_wdata | input | 16 | Write data; high byte used only by 16-bit writes |
| io_rdata | output | 8 | Read data, valid with io_rvalid |
| io_rvalid | output | 1 | Read response, one cycle after the request |
| upd_stb | output | 1 | Register update strobe |
| upd_idx | output | 8 | Pointer targeted by the update |
| upd_data | output | 8 | Byte written by the update |
| acc_err | output | 1 | Refused access width |
| regs_o | output | NREG*8 | All registers, register k at bits 8k+7:8k |

## Verification
A corrupted pointer shows one cycle after the next data access. The wrong register either changes on `regs_o` or is returned on `io_rdata`, and `upd_idx` disagrees with the pointer that was written. A fault in the range check shows at once as a change on `regs_o` after a write to a pointer beyond the bank, or as a non-zero read there. A decoding error that lets a refused width through shows as a state change or read response in the same cycle as `acc_err`. Sweeping every pointer value from 0 to 255 through write, read-back and data access exposes each of these within a few cycles of its cause.

// File: rtl/ixreg_pkg.sv
package ixreg_pkg;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd1;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_PTR_WR,
        OP_PTR_RD,
        OP_DAT_WR,
        OP_DAT_RD,
        OP_PAIR_WR,
        OP_REJECT
    } op_e;

    typedef struct packed {
        op_e        op;
        logic [7:0] lo;
        logic [7:0] hi;
    } access_t;

    function automatic logic is_data_write(op_e op);
        return (op == OP_DAT_WR) || (op == OP_PAIR_WR);
    endfunction

    function automatic logic is_read(op_e op);
        return (op == OP_PTR_RD) || (op == OP_DAT_RD);
    endfunction

endpackage

// File: rtl/ixreg_decode.sv
module ixreg_decode
    import ixreg_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR = 16'h03D4,
    parameter logic [15:0] ALT_ADDR  = 16'h03B4,
    parameter bit          ALT_EN    = 1'b1
) (
    input  logic        alt_sel,
    input  logic        io_wr,
    input  logic        io_rd,
    input  logic [15:0] io_addr,
    input  logic [1:0]  io_size,
    input  logic [15:0] io_wdata,
    output access_t     acc
);

    logic [15:0] base;
    logic        hit_ptr;
    logic        hit_dat;

    always_comb begin
        base    = (ALT_EN && alt_sel) ? ALT_ADDR : BASE_ADDR;
        hit_ptr = (io_addr == base);
        hit_dat = (io_addr == base + 16'd1);
    end

    always_comb begin
        acc.op = OP_NONE;
        acc.lo = io_wdata[7:0];
        acc.hi = io_wdata[15:8];
        if ((io_wr || io_rd) && (hit_ptr || hit_dat)) begin
            if (io_size == SZ_BYTE) begin
                if (io_wr) acc.op = hit_ptr ? OP_PTR_WR : OP_DAT_WR;
                else       acc.op = hit_ptr ? OP_PTR_RD : OP_DAT_RD;
            end else if (io_size == SZ_WORD && io_wr && hit_ptr) begin
                acc.op = OP_PAIR_WR;
            end else begin
                acc.op = OP_REJECT;
            end
        end
    end

endmodule

// File: rtl/ixreg_file.sv
module ixreg_file
    import ixreg_pkg::*;
#(
    parameter int NREG = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  access_t           acc,
    output logic [7:0]        index_q,
    output logic [NREG*8-1:0] regs_flat,
    output logic [7:0]        rd_byte,
    output logic              wr_fire,
    output logic [7:0]        wr_idx,
    output logic [7:0]        wr_byte
);

    logic [7:0] bank [NREG];
    logic [7:0] sel_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q <= 8'h00;
        end else if (acc.op == OP_PTR_WR || acc.op == OP_PAIR_WR) begin
            index_q <= acc.lo;
        end
    end

    always_comb begin
        wr_fire = is_data_write(acc.op);
        wr_idx  = (acc.op == OP_PAIR_WR) ? acc.lo : index_q;
        wr_byte = (acc.op == OP_PAIR_WR) ? acc.hi : acc.lo;
    end

    for (genvar k = 0; k < NREG; k++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                bank[k] <= 8'h00;
            end else if (wr_fire && wr_idx == 8'(k)) begin
                bank[k] <= wr_byte;
            end
        end
        assign regs_flat[k*8 +: 8] = bank[k];
    end

    always_comb begin
        sel_data = 8'h00;
        for (int k = 0; k < NREG; k++) begin
            if (index_q == 8'(k)) sel_data = bank[k];
        end
        rd_byte = (acc.op == OP_PTR_RD) ? index_q : sel_data;
    end

endmodule

// File: rtl/ixreg_resp.sv
module ixreg_resp
    import ixreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  access_t    acc,
    input  logic [7:0] rd_byte,
    input  logic       wr_fire,
    input  logic [7:0] wr_idx,
    input  logic [7:0] wr_byte,
    output logic [7:0] io_rdata,
    output logic       io_rvalid,
    output logic       upd_stb,
    output logic [7:0] upd_idx,
    output logic [7:0] upd_data,
    output logic       acc_err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            io_rdata  <= 8'h00;
            io_rvalid <= 1'b0;
            upd_stb   <= 1'b0;
            upd_idx   <= 8'h00;
            upd_data  <= 8'h00;
            acc_err   <= 1'b0;
        end else begin
            io_rvalid <= is_read(acc.op);
            io_rdata  <= is_read(acc.op) ? rd_byte : 8'h00;
            upd_stb   <= wr_fire;
            upd_idx   <= wr_fire ? wr_idx : 8'h00;
            upd_data  <= wr_fire ? wr_byte : 8'h00;
            acc_err   <= (acc.op == OP_REJECT);
        end
    end

endmodule

// File: rtl/ixreg_bank.sv
module ixreg_bank
    import ixreg_pkg::*;
#(
    parameter int          NREG      = 25,
    parameter logic [15:0] BASE_ADDR = 16'h03D4,
    parameter logic [15:0] ALT_ADDR  = 16'h03B4,
    parameter bit          ALT_EN    = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alt_sel,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [15:0]       io_addr,
    input  logic [1:0]        io_size,
    input  logic [15:0]       io_wdata,
    output logic [7:0]        io_rdata,
    output logic              io_rvalid,
    output logic              upd_stb,
    output logic [7:0]        upd_idx,
    output logic [7:0]        upd_data,
    output logic              acc_err,
    output logic [NREG*8-1:0] regs_o
);

    access_t    acc;
    logic [7:0] index_q;
    logic [7:0] rd_byte;
    logic       wr_fire;
    logic [7:0] wr_idx;
    logic [7:0] wr_byte;

    ixreg_decode #(
        .BASE_ADDR(BASE_ADDR),
        .ALT_ADDR (ALT_ADDR),
        .ALT_EN   (ALT_EN)
    ) u_dec (
        .alt_sel (alt_sel),
        .io_wr   (io_wr),
        .io_rd   (io_rd),
        .io_addr (io_addr),
        .io_size (io_size),
        .io_wdata(io_wdata),
        .acc     (acc)
    );

    ixreg_file #(.NREG(NREG)) u_file (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .index_q  (index_q),
        .regs_flat(regs_o),
        .rd_byte  (rd_byte),
        .wr_fire  (wr_fire),
        .wr_idx   (wr_idx),
        .wr_byte  (wr_byte)
    );

    ixreg_resp u_resp (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .rd_byte  (rd_byte),
        .wr_fire  (wr_fire),
        .wr_idx   (wr_idx),
        .wr_byte  (wr_byte),
        .io_rdata (io_rdata),
        .io_rvalid(io_rvalid),
        .upd_stb  (upd_stb),
        .upd_idx  (upd_idx),
        .upd_data (upd_data),
        .acc_err  (acc_err)
    );

endmodule

// File: rtl/ixreg_bank_chk.sv
module ixreg_bank_chk #(
    parameter int NREG = 25
) (
    input logic              clk,
    input logic              rst,
    input logic              io_wr,
    input logic              io_rvalid,
    input logic              upd_stb,
    input logic [7:0]        upd_idx,
    input logic [7:0]        upd_data,
    input logic              acc_err,
    input logic [7:0]        index_q,
    input logic [NREG*8-1:0] regs_o
);

    assert_reset_zero_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (index_q == 8'h00 && regs_o == '0 && !upd_stb && !acc_err && !io_rvalid));

    assert_upd_lands_R3: assert property (@(posedge clk) disable iff (rst)
        (upd_stb && int'(upd_idx) < NREG) |-> (regs_o[int'(upd_idx)*8 +: 8] == upd_data));

    assert_oob_drop_R4: assert property (@(posedge clk) disable iff (rst)
        (upd_stb && int'(upd_idx) >= NREG) |-> $stable(regs_o));

    assert_strobe_cause_R7: assert property (@(posedge clk) disable iff (rst)
        upd_stb |-> $past(io_wr));

    assert_reject_inert_R8: assert property (@(posedge clk) disable iff (rst)
        acc_err |-> ($stable(regs_o) && $stable(index_q) && !io_rvalid && !upd_stb));

endmodule

bind ixreg_bank ixreg_bank_chk #(.NREG(NREG)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .io_wr    (io_wr),
    .io_rvalid(io_rvalid),
    .upd_stb  (upd_stb),
    .upd_idx  (upd_idx),
    .upd_data (upd_data),
    .acc_err  (acc_err),
    .index_q  (index_q),
    .regs_o   (regs_o)
);

// File: tb/tb_ixreg_bank.sv
module tb_ixreg_bank;

    localparam int          CLK_PERIOD = 10;
    localparam int          NREG       = 25;
    localparam logic [15:0] BASE       = 16'h03D4;
    localparam logic [15:0] ALT        = 16'h03B4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              alt_sel = 1'b0;
    logic              io_wr = 1'b0;
    logic              io_rd = 1'b0;
    logic [15:0]       io_addr = 16'h0000;
    logic [1:0]        io_size = 2'd0;
    logic [15:0]       io_wdata = 16'h0000;
    logic [7:0]        io_rdata;
    logic              io_rvalid;
    logic              upd_stb;
    logic [7:0]        upd_idx;
    logic [7:0]        upd_data;
    logic              acc_err;
    logic [NREG*8-1:0] regs_o;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] m_reg [NREG];
    logic [7:0] m_idx;
    logic [15:0] cur_base;

    always #(CLK_PERIOD/2) clk = ~clk;

    ixreg_bank #(.NREG(NREG), .BASE_ADDR(BASE), .ALT_ADDR(ALT), .ALT_EN(1'b1)) dut (
        .clk(clk), .rst(rst), .alt_sel(alt_sel),
        .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr), .io_size(io_size),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
        .upd_stb(upd_stb), .upd_idx(upd_idx), .upd_data(upd_data),
        .acc_err(acc_err), .regs_o(regs_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // drive one request at a falling edge, observe the registered response at the next
    task automatic access(input logic w, input logic r, input logic [15:0] a,
                          input logic [1:0] sz, input logic [15:0] d);
        @(negedge clk);
        io_wr = w; io_rd = r; io_addr = a; io_size = sz; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0; io_size = 2'd0;
    endtask

    task automatic chk_regs(input string req);
        for (int k = 0; k < NREG; k++) chk(req, int'(regs_o[k*8 +: 8]), int'(m_reg[k]));
    endtask

    task automatic chk_quiet(input string req);
        chk(req, int'(io_rvalid), 0);
        chk(req, int'(upd_stb), 0);
        chk(req, int'(acc_err), 0);
    endtask

    function automatic logic [7:0] m_read(input logic [7:0] p);
        return (int'(p) < NREG) ? m_reg[p] : 8'h00;
    endfunction

    task automatic m_write(input logic [7:0] p, input logic [7:0] d);
        if (int'(p) < NREG) m_reg[p] = d;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < NREG; k++) m_reg[k] = 8'h00;
        m_idx = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk_regs("R1");
        chk_quiet("R1");
        access(1'b0, 1'b1, BASE, 2'd0, 16'h0);
        chk("R1", int'(io_rvalid), 1);
        chk("R1", int'(io_rdata), 0);

        // sweep every pointer value through the alternate pair
        alt_sel = 1'b1;
        cur_base = ALT;
        for (int p = 0; p < 256; p++) begin
            logic [7:0] d;
            d = 8'((p * 7 + 3) ^ 8'hA5);
            access(1'b1, 1'b0, cur_base, 2'd0, {8'hEE, 8'(p)});
            m_idx = 8'(p);
            chk_quiet("R2");
            access(1'b0, 1'b1, cur_base, 2'd0, 16'h0);
            chk("R2", int'(io_rvalid), 1);
            chk("R2", int'(io_rdata), int'(m_idx));
            access(1'b1, 1'b0, cur_base + 16'd1, 2'd0, {8'h77, d});
            m_write(m_idx, d);
            chk("R7", int'(upd_stb), 1);
            chk("R7", int'(upd_idx), int'(m_idx));
            chk("R7", int'(upd_data), int'(d));
            if (p < NREG) chk_regs("R3");
            else          chk_regs("R4");
            access(1'b0, 1'b1, cur_base + 16'd1, 2'd0, 16'h0);
            chk("R5", int'(io_rvalid), 1);
            chk("R5", int'(io_rdata), int'(m_read(m_idx)));
            chk("R7", int'(upd_stb), 0);
        end

        // R6: combined pointer+data writes
        for (int j = 0; j < 6; j++) begin
            int v;
            logic [7:0] d;
            v = (j == 0) ? 0 : (j == 1) ? 3 : (j == 2) ? NREG - 1 : (j == 3) ? NREG : (j == 4) ? 200 : 255;
            d = ~8'(v) ^ 8'h3C;
            access(1'b1, 1'b0, cur_base, 2'd1, {d, 8'(v)});
            m_idx = 8'(v);
            m_write(m_idx, d);
            chk("R6", int'(acc_err), 0);
            chk("R6", int'(upd_stb), 1);
            chk("R6", int'(upd_idx), v);
            chk("R6", int'(upd_data), int'(d));
            chk_regs("R6");
            access(1'b0, 1'b1, cur_base, 2'd0, 16'h0);
            chk("R6", int'(io_rdata), v);
            access(1'b0, 1'b1, cur_base + 16'd1, 2'd0, 16'h0);
            chk("R6", int'(io_rdata), int'(m_read(m_idx)));
        end

        // R8: refused widths
        access(1'b1, 1'b0, cur_base, 2'd0, 16'h0002);
        m_idx = 8'h02;
        for (int sz = 1; sz < 4; sz++) begin
            for (int off = 0; off < 2; off++) begin
                for (int w = 0; w < 2; w++) begin
                    if (!(sz == 1 && w == 1 && off == 0)) begin
                        access(w[0], ~w[0], cur_base + 16'(off), 2'(sz), 16'h5A19);
                        chk("R8", int'(acc_err), 1);
                        chk("R8", int'(io_rvalid), 0);
                        chk("R8", int'(upd_stb), 0);
                        chk_regs("R8");
                        access(1'b0, 1'b1, cur_base, 2'd0, 16'h0);
                        chk("R8", int'(io_rdata), int'(m_idx));
                    end
                end
            end
        end

        // R9: address selection
        alt_sel = 1'b0;
        access(1'b1, 1'b0, ALT + 16'd1, 2'd0, 16'h00C3);
        chk_quiet("R9");
        chk_regs("R9");
        access(1'b1, 1'b0, ALT, 2'd1, 16'h4401);
        chk_quiet("R9");
        access(1'b1, 1'b0, 16'h03C4, 2'd0, 16'h0011);
        chk_quiet("R9");
        access(1'b0, 1'b1, BASE, 2'd0, 16'h0);
        chk("R9", int'(io_rvalid), 1);
        chk("R9", int'(io_rdata), int'(m_idx));
        access(1'b1, 1'b0, BASE + 16'd1, 2'd0, 16'h0096);
        m_write(m_idx, 8'h96);
        chk("R9", int'(upd_stb), 1);
        chk_regs("R9");
        access(1'b0, 1'b1, BASE + 16'd1, 2'd0, 16'h0);
        chk("R9", int'(io_rdata), 8'h96);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule